// File: doc/BRIEF.md
# Microsecond Tick Divider

This block turns a system clock of any supported frequency into a periodic single-cycle tick. The tick is meant to be about 1 MHz, so that a single-wire bus master can count microseconds with it. The divide ratio is held in an 8-bit code register, which is loaded by a plain write strobe.

The ratio is the product of two factors. The first is an odd prescale of 1, 3, 5 or 7. The second is a power of two, from 1 to 128. A 48 MHz clock, for example, uses code 0x91, which gives 3 × 16 = 48. The most significant bit of the code enables the divider. The clock-to-code lookup is done by software. After loading a code, the master should let the tick run for a while before it starts its first bus reset.

Top module: `tick_divider`

## Requirements
- R1: While `rst_n` is low, `tick` is low and the code register clears to 0x00, which means the divider is disabled.
- R2: While code bit 7 is 0, `tick` stays low and both counter stages stay at zero.
- R3: Code bits [1:0] select the prescale. The value `s` gives a prescale of 2·s+1, so 0 gives 1, 1 gives 3, 2 gives 5 and 3 gives 7.
- R4: Code bits [4:2] hold an exponent `e` from 0 to 7, which adds a further divide by 2^e.
- R5: When enabled, `tick` pulses once every N = (2·s+1)·2^e clock cycles. Examples: 0x80 gives 1, 0x84 gives 2, 0x85 gives 6, 0x86 gives 10, 0x91 gives 48 and 0x9C gives 128.
- R6: A write of a new code to `cfg_data` is taken when `cfg_wr` is high at a clock edge, and that write clears both counter stages. `tick` is low in the cycle after the write edge. The first tick rises on the N-th edge after the write edge.
- R7: For N > 1 each tick lasts exactly one clock cycle. For N = 1, `tick` stays high continuously.
- R8: Code bits [6:5] have no effect on the ratio or on the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Write strobe for the code register |
| cfg_data | input | 8 | Divider code: bit 7 enable, [4:2] exponent, [1:0] prescale select |
| tick | output | 1 | Single-cycle timing pulse |

## Verification
The tick is the only output, so any fault in the counter state shows up as a tick at the wrong cycle. A prescale counter that wraps early or late shifts the first tick after the next write by at least one cycle. A power-of-two stage that is not cleared on a write makes the first period short, and this is visible within N cycles of the write. The bench tracks the expected cycle count since each write and compares `tick` on every clock. A missing, late, doubled or stretched pulse is therefore caught at the first cycle where it happens.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;
  localparam int CODE_W  = 8;
  localparam int SEL_W   = 2;
  localparam int EXP_W   = 3;
  localparam int EN_BIT  = CODE_W - 1;
  localparam int EXP_LSB = SEL_W;

  // Prescale of 2*sel+1 means a terminal count of 2*sel
  function automatic logic [SEL_W:0] pre_last(input logic [SEL_W-1:0] sel);
    return {sel, 1'b0};
  endfunction
endpackage

// File: rtl/tdiv_prescale.sv
module tdiv_prescale #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_nxt;

  assign wrap = run && (cnt == last);

  always_comb begin
    if (clr || !run)  cnt_nxt = '0;
    else if (wrap)    cnt_nxt = '0;
    else              cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tdiv_pow2.sv
module tdiv_pow2 #(
  parameter int EXP_W = 3,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             step,
  input  logic [EXP_W-1:0] expo,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_nxt;

  // Mask of expo low ones; all ones in the masked bits marks the last step
  assign mask = ~({CNT_W{1'b1}} << expo);
  assign done = step && ((cnt & mask) == mask);

  always_comb begin
    if (clr || !run)  cnt_nxt = '0;
    else if (done)    cnt_nxt = '0;
    else if (step)    cnt_nxt = cnt + 1'b1;
    else              cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_data,
  output logic              tick
);
  localparam int PRE_W = SEL_W + 1;
  localparam int POW_W = (1 << EXP_W) - 1;

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic              enable_q;
  logic [SEL_W-1:0]  sel;
  logic [EXP_W-1:0]  expo;
  logic [PRE_W-1:0]  pre_last_v;
  logic [PRE_W-1:0]  pre_cnt;
  logic [POW_W-1:0]  pow_cnt;
  logic              pre_wrap;
  logic              pow_done;
  logic              tick_nxt;

  assign enable_q   = code_q[EN_BIT];
  assign sel        = code_q[SEL_W-1:0];
  assign expo       = code_q[EXP_LSB +: EXP_W];
  assign pre_last_v = pre_last(sel);

  always_comb begin
    code_nxt = code_q;
    if (cfg_wr) code_nxt = cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt;
  end

  tdiv_prescale #(.W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cfg_wr),
    .run  (enable_q),
    .last (pre_last_v),
    .cnt  (pre_cnt),
    .wrap (pre_wrap)
  );

  tdiv_pow2 #(.EXP_W(EXP_W)) u_pow (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cfg_wr),
    .run  (enable_q),
    .step (pre_wrap),
    .expo (expo),
    .cnt  (pow_cnt),
    .done (pow_done)
  );

  assign tick_nxt = pow_done && !cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= tick_nxt;
  end
endmodule

// File: rtl/tick_divider_chk.sv
module tick_divider_chk #(
  parameter int PRE_W = 3,
  parameter int POW_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             enable_q,
  input logic [4:0]       ratio_bits,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] pre_last_v,
  input logic [POW_W-1:0] pow_cnt,
  input logic             tick
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |=> !tick);

  // R2
  disabled_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q && !$past(enable_q)) |-> (pre_cnt == '0 && pow_cnt == '0));

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last_v);

  // R6
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!tick && pre_cnt == '0 && pow_cnt == '0));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_bits != 5'd0) |=> !tick);

  // R5
  tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (pre_cnt == '0));
endmodule

bind tick_divider tick_divider_chk #(.PRE_W(PRE_W), .POW_W(POW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .enable_q  (enable_q),
  .ratio_bits(code_q[4:0]),
  .pre_cnt   (pre_cnt),
  .pre_last_v(pre_last_v),
  .pow_cnt   (pow_cnt),
  .tick      (tick)
);

// File: tb/tick_divider_bench.sv
module tick_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_data;
  logic       tick;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 0;

  // reference model state
  bit     m_en;
  int     m_n;
  longint m_cyc;
  bit     m_tick;

  tick_divider u_tick_divider (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_data(cfg_data),
    .tick    (tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: count cycles since the last write, tick on multiples of N
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_n = 1; m_cyc = 0; m_tick = 0;
    end else if (cfg_wr) begin
      m_en   = cfg_data[7];
      m_n    = (2 * int'(cfg_data[1:0]) + 1) * (1 << cfg_data[4:2]);
      m_cyc  = 0;
      m_tick = 0;
    end else if (m_en) begin
      m_cyc  = m_cyc + 1;
      m_tick = (m_cyc % m_n) == 0;
    end else begin
      m_tick = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (tick !== m_tick) begin
        errors++;
        $display("FAIL %s: tick=%0b expected=%0b at %0t", tag, tick, m_tick, $time);
      end
    end
  end

  task automatic write_code(input logic [7:0] code);
    @(negedge clk);
    cfg_wr   = 1'b1;
    cfg_data = code;
    @(negedge clk);
    cfg_wr   = 1'b0;
    cfg_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cfg_wr = 1'b0; cfg_data = 8'h00; rst_n = 1'b0;
    tag = "R1";
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(5);
    tag = "R2"; write_code(8'h1F); idle(40);
    tag = "R5"; write_code(8'h80); idle(10);
    tag = "R3"; write_code(8'h81); idle(30);
    write_code(8'h82); idle(30);
    write_code(8'h83); idle(30);
    tag = "R4"; write_code(8'h84); idle(30);
    write_code(8'h85); idle(40);
    write_code(8'h86); idle(50);
    tag = "R5"; write_code(8'h91); idle(200);
    write_code(8'h9C); idle(400);
    tag = "R7"; write_code(8'h9F); idle(2000);
    tag = "R8"; write_code(8'hE3); idle(40);
    write_code(8'hFD); idle(200);
    tag = "R6"; write_code(8'h87); idle(20);
    write_code(8'h87); idle(3);
    write_code(8'h8B); idle(100);
    tag = "R2"; write_code(8'h03); idle(60);
    tag = "R6"; write_code(8'h82); idle(2); write_code(8'h82); idle(30);
    tag = "R1";
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(30);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: expected=finish actual=timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule